// File: doc/BRIEF.md
# Slow-Rate Sample Hold Repeater

This block connects a converter channel that completes conversions slowly to a system sample clock that may strobe much faster. It keeps the most recently completed conversion in a holding register. On each accepted sample strobe it returns that value, so that between two completed conversions the same value is returned on every strobe. A flag on the output marks each result whose value was already returned on an earlier result.

The block also sets the order of acquisition at the start of a task. After reset it waits for a commit strobe. The commit produces exactly one result, which is the first point. The block then ignores sample strobes until the start trigger arrives. From the cycle after the trigger, every sample strobe produces a result. Conversions are captured in every phase, so the value returned after the trigger is always the newest one available. Only reset returns the block to the waiting state. Converter control and sample storage belong to other blocks.

Top module: `sample_hold_repeater`

## Requirements
- R1: While reset is asserted and after it is released, `outValid`, `outData` and `outRepeat` are 0, the held value is zero, and the block waits for a commit.
- R2: In the waiting state a `commitStb` produces exactly one result one cycle later, carrying the held value (zero if nothing has converted since reset), and moves the block to the armed state.
- R3: In the armed state no `sampleStb` produces a result, including a strobe in the same cycle as `startTrig`; `startTrig` moves the block to the running state.
- R4: In the running state every `sampleStb` produces a result one cycle later.
- R5: Each result carries the most recently completed conversion, and the same value is returned on every result until a new `convDone` arrives.
- R6: A `convDone` in the same cycle as an accepted strobe (sample or commit) puts that cycle's `convData` on the result.
- R7: `outRepeat` is 1 on a result whose value was already returned on an earlier result since reset, and 0 otherwise. The zero held after reset counts as not yet returned.
- R8: `startTrig` in the waiting state and `commitStb` in the armed or running state have no effect.
- R9: `outValid` is high for exactly one cycle per accepted strobe, and `outRepeat` is 0 whenever `outValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleStb | input | 1 | System sample clock strobe, one cycle |
| convDone | input | 1 | Conversion completed this cycle |
| convData | input | DATA_W | Result of the completed conversion |
| commitStb | input | 1 | Task commit, takes the first point |
| startTrig | input | 1 | Start trigger, enables later points |
| outValid | output | 1 | Result present this cycle |
| outData | output | DATA_W | Result value |
| outRepeat | output | 1 | Result value was already returned earlier |

## Verification
The assertions assume that the strobe inputs are single-cycle pulses and that `convData` is meaningful only while `convDone` is high. They also assume that the only way back to the waiting state is reset. The stimulus drives every input on the falling edge and holds it for one cycle. It never relies on a value of `convData` outside a `convDone` cycle. It returns to the waiting state only by pulsing `rstN`, and it covers coincident strobes, trigger and conversion on purpose.

// File: rtl/shr_pkg.sv
package shr_pkg;
  typedef enum logic [1:0] {
    PH_WAIT  = 2'd0,
    PH_ARMED = 2'd1,
    PH_RUN   = 2'd2
  } phase_t;

  typedef struct packed {
    logic emit;     // return the held value on the next cycle
    logic running;  // trigger has been seen
  } ctrlStrobes_t;
endpackage

// File: rtl/shr_ctrl.sv
module shr_ctrl
  import shr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         sampleStb,
  input  logic         commitStb,
  input  logic         startTrig,
  output ctrlStrobes_t strobes
);
  phase_t phase, phaseNext;

  always_comb begin
    phaseNext       = phase;
    strobes.emit    = 1'b0;
    strobes.running = (phase == PH_RUN);
    unique case (phase)
      PH_WAIT: if (commitStb) begin
        strobes.emit = 1'b1;
        phaseNext    = PH_ARMED;
      end
      PH_ARMED: if (startTrig) phaseNext = PH_RUN;
      PH_RUN:   strobes.emit = sampleStb;
      default:  phaseNext = PH_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_WAIT;
    else       phase <= phaseNext;
  end

  assert_commit_emits_R2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_WAIT && commitStb) |=> (phase == PH_ARMED));
  assert_armed_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_ARMED) |-> !strobes.emit);
  assert_trigger_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_WAIT && !commitStb) |=> (phase == PH_WAIT));
  assert_run_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_RUN) |=> (phase == PH_RUN));
endmodule

// File: rtl/shr_datapath.sv
module shr_datapath
  import shr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              convDone,
  input  logic [DATA_W-1:0] convData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outRepeat
);
  logic [DATA_W-1:0] heldData;
  logic              unsent;   // held value not yet returned
  logic [DATA_W-1:0] pickData;

  assign pickData = convDone ? convData : heldData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldData  <= '0;
      unsent    <= 1'b1;
      outValid  <= 1'b0;
      outData   <= '0;
      outRepeat <= 1'b0;
    end else begin
      if (convDone) heldData <= convData;
      if (strobes.emit)  unsent <= 1'b0;
      else if (convDone) unsent <= 1'b1;
      outValid  <= strobes.emit;
      outRepeat <= strobes.emit && !(unsent || convDone);
      if (strobes.emit) outData <= pickData;
    end
  end

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.emit |=> outValid);
  assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.emit |=> !outValid);
  assert_repeat_qualified_R7: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !outRepeat);
  assert_fresh_data_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.emit && convDone) |=> (outData == $past(convData) && !outRepeat));
  assert_hold_value_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.emit && !convDone && !unsent) |=> ($stable(outData) && outRepeat));
endmodule

// File: rtl/sample_hold_repeater.sv
module sample_hold_repeater
  import shr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleStb,
  input  logic              convDone,
  input  logic [DATA_W-1:0] convData,
  input  logic              commitStb,
  input  logic              startTrig,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outRepeat
);
  ctrlStrobes_t strobes;

  shr_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sampleStb (sampleStb),
    .commitStb (commitStb),
    .startTrig (startTrig),
    .strobes   (strobes)
  );

  shr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .convDone  (convDone),
    .convData  (convData),
    .outValid  (outValid),
    .outData   (outData),
    .outRepeat (outRepeat)
  );
endmodule

// File: tb/tb_sample_hold_repeater.sv
module tb_sample_hold_repeater;
  localparam int DATA_W = 16;

  typedef struct {
    logic [DATA_W-1:0] data;
    logic              rep;
    string             tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleStb = 1'b0, convDone = 1'b0, commitStb = 1'b0, startTrig = 1'b0;
  logic [DATA_W-1:0] convData = '0;
  logic outValid, outRepeat;
  logic [DATA_W-1:0] outData;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;
  expItem_t expQ[$];

  // bench model, built from the requirements
  int mPhase = 0;            // 0 wait, 1 armed, 2 run
  logic [DATA_W-1:0] mHeld = '0;
  bit mUnsent = 1;

  always #10 clk = ~clk;     // 50 MHz

  sample_hold_repeater #(.DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .convDone(convDone),
    .convData(convData), .commitStb(commitStb), .startTrig(startTrig),
    .outValid(outValid), .outData(outData), .outRepeat(outRepeat)
  );

  task automatic cyc(input bit smp, input bit cv, input logic [DATA_W-1:0] d,
                     input bit cm, input bit tr, input string tag);
    bit emit;
    expItem_t it;
    @(negedge clk);
    sampleStb = smp; convDone = cv; convData = cv ? d : 16'hDEAD;
    commitStb = cm; startTrig = tr;
    emit = (mPhase == 0 && cm) || (mPhase == 2 && smp);
    if (emit) begin
      it.data = cv ? d : mHeld;
      it.rep  = !(mUnsent || cv);
      it.tag  = tag;
      expQ.push_back(it);
      mUnsent = 0;
    end else if (cv) mUnsent = 1;
    if (cv) mHeld = d;
    if (mPhase == 0 && cm) mPhase = 1;
    else if (mPhase == 1 && tr) mPhase = 2;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, '0, 0, 0, "idle");
  endtask

  task automatic doReset();
    @(negedge clk);
    sampleStb = 0; convDone = 0; commitStb = 0; startTrig = 0;
    rstN = 0;
    mPhase = 0; mHeld = '0; mUnsent = 1;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || outData !== '0 || outRepeat !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset outputs: valid=%b data=%h rep=%b expected 0/0000/0",
               outValid, outData, outRepeat);
    end
    rstN = 1;
  endtask

  // monitor: compare every result with the scoreboard
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (outValid === 1'b1) begin
        checks++;
        if (expQ.size() == 0) begin
          failures++;
          $display("FAIL R3/R8 unexpected result: data=%h expected none", outData);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          if (outData !== e.data || outRepeat !== e.rep) begin
            failures++;
            $display("FAIL %s: data=%h rep=%b expected data=%h rep=%b",
                     e.tag, outData, outRepeat, e.data, e.rep);
          end
        end
      end else if (outRepeat !== 1'b0) begin
        checks++; failures++;
        $display("FAIL R9 repeat without valid: rep=%b expected 0", outRepeat);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired: cycles=%0d expected < 20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    doReset();
    // R8: strobes before commit are ignored
    cyc(1, 0, '0, 0, 0, "R8 sample before commit");
    cyc(0, 0, '0, 0, 1, "R8 trigger before commit");
    idle(2);
    // R2/R7: commit returns reset value as fresh
    cyc(0, 0, '0, 1, 0, "R2 R7 commit first point");
    idle(1);
    // R3: armed phase ignores samples, captures conversions
    cyc(1, 0, '0, 0, 0, "R3 sample while armed");
    cyc(0, 1, 16'h0011, 0, 0, "R3 conversion while armed");
    cyc(1, 0, '0, 0, 0, "R3 sample while armed");
    cyc(0, 0, '0, 1, 0, "R8 second commit");
    cyc(1, 0, '0, 0, 1, "R3 sample with trigger");
    idle(1);
    // R4/R5/R7: running
    cyc(1, 0, '0, 0, 0, "R4 R5 first run sample");
    cyc(1, 0, '0, 0, 0, "R5 R7 repeat");
    cyc(1, 0, '0, 0, 0, "R5 R7 repeat");
    cyc(0, 1, 16'h0022, 0, 0, "R5 conversion");
    cyc(1, 0, '0, 0, 0, "R5 new value");
    cyc(1, 1, 16'h0033, 0, 0, "R6 coincident conversion");
    cyc(1, 0, '0, 0, 0, "R7 repeat after coincident");
    cyc(0, 0, '0, 1, 0, "R8 commit while running");
    idle(2);
    // R5: fast samples, slow conversions
    for (int i = 0; i < 24; i++)
      cyc(1, (i % 5) == 2, DATA_W'(16'h0100 + i), 0, 0, "R5 R9 burst");
    for (int i = 0; i < 10; i++)
      cyc((i % 2) == 0, (i % 3) == 0, DATA_W'(16'h0200 + i), 0, 0, "R4 R6 mixed");
    idle(2);
    // second task: reset, commit with coincident conversion
    doReset();
    cyc(0, 1, 16'h0044, 1, 0, "R2 R6 commit with conversion");
    cyc(0, 0, '0, 0, 1, "R3 trigger");
    cyc(1, 0, '0, 0, 0, "R7 repeat of commit point");
    idle(3);
    done = 1;
    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL R9 missing results: outstanding=%0d expected 0", expQ.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule